// File: doc/BRIEF.md
# Nested interrupt priority resolver

This block decides which of many pending interrupt sources should be serviced next and whether that source may interrupt the handler already running. Each source has an 8-bit priority field. Only the upper bits of that field are kept: six bits by default, which gives 64 levels. A smaller stored value means a more urgent source. When several pending sources share the best level, the one with the smallest index wins.

The block keeps a stack of the levels of the handlers that are running, one entry per nesting depth. A pending source preempts the running handler only if its level is strictly more urgent. Saving the processor state before a new handler is modelled as a fixed wait, after which the block reports the handler entry and pushes the new level. When a handler returns, the block normally pops the stack and restores the level beneath. If a pending source would beat that restored level, the block moves straight into the new handler: it replaces the top entry and skips the unstack and restack steps.

Software or a bus bridge programs the priorities through a simple write port and reads them back through a read port. The sources hold their pending lines high until they see their own index on the entry report.

Top module: `irq_nest_arbiter`

## Requirements
- R1: A priority write to an index below NUM_SRC stores the upper LVL_W bits of the write data. The read port returns those bits in the upper LVL_W positions and zero in the lower PRIO_W-LVL_W positions. A write to an index at or above NUM_SRC changes nothing, and a read of such an index returns zero.
- R2: `sel_valid_o` is high exactly when some pending line is high. `sel_id_o` then names the pending source with the smallest stored level.
- R3: Among pending sources with the same smallest level, `sel_id_o` names the lowest index.
- R4: `preempt_o` is high in a cycle exactly when three things hold: no entry wait is in progress, no return is accepted in that cycle, and the selected level is numerically below the active level. With nothing running, the active level reads as 2^LVL_W.
- R5: A pending source whose level equals the active level never raises `preempt_o`.
- R6: `enter_o` rises with `enter_id_o` equal to the preempting source exactly ENTRY_LAT cycles after the `preempt_o` cycle. From the next cycle, `act_lvl_o` shows that source's level.
- R7: `exc_ret_i` is ignored while the stack is empty or while an entry wait is in progress. It changes neither the stack nor `act_lvl_o`.
- R8: An accepted return with no pending level strictly below the level beneath the top pops the stack. `act_lvl_o` then shows the previous level.
- R9: On an accepted return, if the selected level is strictly below the level beneath the top (2^LVL_W when only one entry remains), `tail_o` and `enter_o` are high in that same cycle with `enter_id_o` equal to `sel_id_o`. The stack depth stays the same and the top entry takes the new level.
- R10: The stack holds 2^LVL_W entries. This is enough to nest one handler at every level, and the nest unwinds one level per return in reverse order.
- R11: After reset, all stored priorities are zero, the stack is empty (`act_lvl_o` = 2^LVL_W), and `preempt_o`, `enter_o` and `tail_o` are low while nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | NUM_SRC | Pending line per source |
| prio_we_i | input | 1 | Priority write strobe |
| prio_waddr_i | input | ID_W | Source index of the write |
| prio_wdata_i | input | PRIO_W | Priority field written |
| prio_raddr_i | input | ID_W | Source index of the read |
| prio_rdata_o | output | PRIO_W | Priority field read back |
| exc_ret_i | input | 1 | Running handler returns this cycle |
| sel_valid_o | output | 1 | Some source is pending |
| sel_id_o | output | ID_W | Index of the winning pending source |
| preempt_o | output | 1 | Entry wait starts for the winning source |
| enter_o | output | 1 | A handler starts this cycle |
| enter_id_o | output | ID_W | Index of the source whose handler starts |
| tail_o | output | 1 | The start comes directly from a return (no unstack) |
| act_lvl_o | output | LVL_W+1 | Active level, 2^LVL_W when idle |

## Verification
The bench builds the block with NUM_SRC=6, LVL_W=2 and ENTRY_LAT=3. With six sources, all 64 pending patterns can be swept under three different priority maps, covering ties and every ordering of the winner. With four levels, a single chain of preemptions fills the whole stack, so both the full-depth nest and its level-by-level unwind are exercised. With a wait of three cycles, the entry report lands at a known cycle, and a return can be placed inside the wait to confirm that it is ignored.

// File: rtl/irq_nest_pkg.sv
// Shared types for the nested interrupt priority resolver.
// Assumes: one resolver instance per core; no parameters live here.
package irq_nest_pkg;

    // Control state of the entry sequencer.
    typedef enum logic {
        ST_RUN   = 1'b0,   // handler (or thread) running, decisions allowed
        ST_STACK = 1'b1    // fixed state-saving wait before a handler starts
    } nest_state_e;

endpackage

// File: rtl/irq_prio_store.sv
// Priority field storage for all sources.
// Keeps only the upper LVL_W bits of each PRIO_W-bit field and returns zero in
// the dropped low bits. Writes and reads outside 0..NUM_SRC-1 have no effect
// and read as zero. Assumes LVL_W < PRIO_W.
module irq_prio_store #(
    parameter int NUM_SRC = 112,
    parameter int PRIO_W  = 8,
    parameter int LVL_W   = 6,
    parameter int ID_W    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [ID_W-1:0]            waddr_i,
    input  logic [PRIO_W-1:0]          wdata_i,
    input  logic [ID_W-1:0]            raddr_i,
    output logic [PRIO_W-1:0]          rdata_o,
    output logic [NUM_SRC*LVL_W-1:0]   lvl_flat_o
);

    localparam int DROP_W = PRIO_W - LVL_W;

    logic [LVL_W-1:0] lvl_q [NUM_SRC];
    logic             wr_hit;
    logic             rd_hit;
    logic             unused_low_bits;

    // The dropped low bits of the write data are intentionally discarded.
    assign unused_low_bits = ^wdata_i[DROP_W-1:0];

    assign wr_hit = we_i && (int'(waddr_i) < NUM_SRC);
    assign rd_hit = int'(raddr_i) < NUM_SRC;

    // Capture the upper bits of a write into the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                lvl_q[i] <= '0;
            end
        end else if (wr_hit) begin
            lvl_q[waddr_i] <= wdata_i[PRIO_W-1:DROP_W];
        end
    end

    // Read back the stored level aligned to the top of the field.
    always_comb begin
        rdata_o = '0;
        if (rd_hit) begin
            rdata_o = PRIO_W'(lvl_q[raddr_i]) << DROP_W;
        end
    end

    // Present all levels as one flat vector for the selection tree.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flat
        assign lvl_flat_o[i*LVL_W +: LVL_W] = lvl_q[i];
    end

endmodule

// File: rtl/irq_pick_tree.sv
// Combinational tournament that finds the most urgent pending source.
// Pads the sources to a power of two and compares pairs level by level. At
// each node the left (lower index) side wins unless the right side is pending
// and strictly more urgent, so ties resolve to the lower index.
module irq_pick_tree #(
    parameter int NUM_SRC = 112,
    parameter int LVL_W   = 6,
    parameter int ID_W    = 7
) (
    input  logic [NUM_SRC-1:0]       pend_i,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_flat_i,
    output logic                     best_v_o,
    output logic [ID_W-1:0]          best_id_o,
    output logic [LVL_W-1:0]         best_lvl_o
);

    localparam int DEPTH = $clog2(NUM_SRC);
    localparam int NP    = 1 << DEPTH;

    for (genvar lv = 0; lv <= DEPTH; lv++) begin : g_lvl
        localparam int W = NP >> lv;
        logic             v   [W];
        logic [ID_W-1:0]  id  [W];
        logic [LVL_W-1:0] lvl [W];

        if (lv == 0) begin : g_leaf
            for (genvar j = 0; j < W; j++) begin : g_j
                if (j < NUM_SRC) begin : g_real
                    // Leaf for a real source.
                    assign v[j]   = pend_i[j];
                    assign id[j]  = ID_W'(j);
                    assign lvl[j] = lvl_flat_i[j*LVL_W +: LVL_W];
                end else begin : g_pad
                    // Padding leaf that never wins.
                    assign v[j]   = 1'b0;
                    assign id[j]  = '0;
                    assign lvl[j] = '1;
                end
            end
        end else begin : g_node
            for (genvar j = 0; j < W; j++) begin : g_j
                logic take_r;
                // Right child wins only when pending and strictly more urgent.
                assign take_r = g_lvl[lv-1].v[2*j+1] &&
                                (!g_lvl[lv-1].v[2*j] ||
                                 (g_lvl[lv-1].lvl[2*j+1] < g_lvl[lv-1].lvl[2*j]));
                assign v[j]   = g_lvl[lv-1].v[2*j] | g_lvl[lv-1].v[2*j+1];
                assign id[j]  = take_r ? g_lvl[lv-1].id[2*j+1]  : g_lvl[lv-1].id[2*j];
                assign lvl[j] = take_r ? g_lvl[lv-1].lvl[2*j+1] : g_lvl[lv-1].lvl[2*j];
            end
        end
    end

    assign best_v_o   = g_lvl[DEPTH].v[0];
    assign best_id_o  = g_lvl[DEPTH].id[0];
    assign best_lvl_o = g_lvl[DEPTH].lvl[0];

endmodule

// File: rtl/irq_lvl_stack.sv
// Stack of active levels, one entry per nested handler.
// Push adds a level, pop restores the one beneath, and replace overwrites the
// top entry without changing the depth. An empty stack (or a missing entry
// beneath the top) reads as the idle code 2^LVL_W, which is less urgent than
// any real level. Assumes at most one of push/pop/replace per cycle and no
// push when full.
module irq_lvl_stack #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             repl_i,
    input  logic [LVL_W-1:0] din_i,
    output logic [LVL_W:0]   top_o,
    output logic [LVL_W:0]   below_o,
    output logic [LVL_W:0]   sp_o,
    output logic             full_o
);

    localparam int DEPTH = 1 << LVL_W;
    localparam int SP_W  = LVL_W + 1;
    localparam logic [LVL_W:0] IDLE_LVL = {1'b1, {LVL_W{1'b0}}};

    logic [LVL_W-1:0] mem_q [DEPTH];
    logic [SP_W-1:0]  sp_q;
    logic [SP_W-1:0]  sp_m1;
    logic [SP_W-1:0]  sp_m2;
    logic [LVL_W-1:0] top_idx;
    logic [LVL_W-1:0] below_idx;

    assign sp_m1     = sp_q - SP_W'(1);
    assign sp_m2     = sp_q - SP_W'(2);
    assign top_idx   = sp_m1[LVL_W-1:0];
    assign below_idx = sp_m2[LVL_W-1:0];

    // Update the depth and the entries on push, replace or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (push_i) begin
            mem_q[sp_q[LVL_W-1:0]] <= din_i;
            sp_q                   <= sp_q + SP_W'(1);
        end else if (repl_i) begin
            mem_q[top_idx] <= din_i;
        end else if (pop_i) begin
            sp_q <= sp_m1;
        end
    end

    // Present the top and the entry beneath, or idle where none exists.
    always_comb begin
        top_o   = (sp_q == '0) ? IDLE_LVL : {1'b0, mem_q[top_idx]};
        below_o = (sp_q < SP_W'(2)) ? IDLE_LVL : {1'b0, mem_q[below_idx]};
    end

    assign sp_o   = sp_q;
    assign full_o = (sp_q == SP_W'(DEPTH));

endmodule

// File: rtl/irq_nest_arbiter.sv
// Nested interrupt priority resolver (top).
// Combines the priority store, the selection tree and the active-level stack.
// A strictly more urgent pending source starts a fixed ENTRY_LAT-cycle wait
// that stands in for state saving; when it ends, the handler entry is
// reported and its level pushed. A return pops the stack unless a pending
// source beats the restored level; in that case the top entry is replaced
// directly (tail-chain). Assumes pending lines stay high until the source's
// entry is reported, and ENTRY_LAT >= 1.
module irq_nest_arbiter #(
    parameter int NUM_SRC   = 112,
    parameter int PRIO_W    = 8,
    parameter int LVL_W     = 6,
    parameter int ENTRY_LAT = 12,
    parameter int ID_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               prio_we_i,
    input  logic [ID_W-1:0]    prio_waddr_i,
    input  logic [PRIO_W-1:0]  prio_wdata_i,
    input  logic [ID_W-1:0]    prio_raddr_i,
    output logic [PRIO_W-1:0]  prio_rdata_o,
    input  logic               exc_ret_i,
    output logic               sel_valid_o,
    output logic [ID_W-1:0]    sel_id_o,
    output logic               preempt_o,
    output logic               enter_o,
    output logic [ID_W-1:0]    enter_id_o,
    output logic               tail_o,
    output logic [LVL_W:0]     act_lvl_o
);

    import irq_nest_pkg::*;

    localparam int CNT_W = $clog2(ENTRY_LAT + 1);

    logic [NUM_SRC*LVL_W-1:0] lvl_flat;
    logic                     best_v;
    logic [ID_W-1:0]          best_id;
    logic [LVL_W-1:0]         best_lvl;

    logic [LVL_W:0]           stk_top;
    logic [LVL_W:0]           stk_below;
    logic [LVL_W:0]           stk_sp;
    logic                     stk_full;
    logic                     stk_push;
    logic                     stk_pop;
    logic                     stk_repl;
    logic [LVL_W-1:0]         stk_din;

    nest_state_e              state_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [ID_W-1:0]          hold_id_q;
    logic [LVL_W-1:0]         hold_lvl_q;

    logic                     ret_ok;
    logic                     do_tail;
    logic                     do_pre;
    logic                     wait_done;

    irq_prio_store #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .LVL_W   (LVL_W),
        .ID_W    (ID_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (prio_we_i),
        .waddr_i    (prio_waddr_i),
        .wdata_i    (prio_wdata_i),
        .raddr_i    (prio_raddr_i),
        .rdata_o    (prio_rdata_o),
        .lvl_flat_o (lvl_flat)
    );

    irq_pick_tree #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .ID_W    (ID_W)
    ) u_tree (
        .pend_i     (pend_i),
        .lvl_flat_i (lvl_flat),
        .best_v_o   (best_v),
        .best_id_o  (best_id),
        .best_lvl_o (best_lvl)
    );

    irq_lvl_stack #(
        .LVL_W (LVL_W)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (stk_push),
        .pop_i   (stk_pop),
        .repl_i  (stk_repl),
        .din_i   (stk_din),
        .top_o   (stk_top),
        .below_o (stk_below),
        .sp_o    (stk_sp),
        .full_o  (stk_full)
    );

    // Decide return handling, tail-chain and preemption for this cycle.
    always_comb begin
        ret_ok    = exc_ret_i && (state_q == ST_RUN) && (stk_sp != '0);
        do_tail   = ret_ok && best_v && ({1'b0, best_lvl} < stk_below);
        do_pre    = (state_q == ST_RUN) && !ret_ok && best_v &&
                    ({1'b0, best_lvl} < stk_top);
        wait_done = (state_q == ST_STACK) && (cnt_q == '0);
    end

    // Drive the stack from the decisions.
    always_comb begin
        stk_push = wait_done;
        stk_repl = do_tail;
        stk_pop  = ret_ok && !do_tail;
        stk_din  = do_tail ? best_lvl : hold_lvl_q;
    end

    // Sequence the state-saving wait and hold the chosen source through it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            cnt_q      <= '0;
            hold_id_q  <= '0;
            hold_lvl_q <= '0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (do_pre) begin
                        state_q    <= ST_STACK;
                        cnt_q      <= CNT_W'(ENTRY_LAT - 1);
                        hold_id_q  <= best_id;
                        hold_lvl_q <= best_lvl;
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_RUN;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Outputs.
    assign sel_valid_o = best_v;
    assign sel_id_o    = best_id;
    assign preempt_o   = do_pre;
    assign enter_o     = wait_done | do_tail;
    assign enter_id_o  = do_tail ? best_id : hold_id_q;
    assign tail_o      = do_tail;
    assign act_lvl_o   = stk_top;

endmodule

// Assertion checker bound to the resolver.
// Watches the outward pulses and the stack hand-shake for the nesting rules.
module irq_nest_arbiter_chk #(
    parameter int LVL_W     = 6,
    parameter int ENTRY_LAT = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           preempt_o,
    input logic           enter_o,
    input logic           tail_o,
    input logic [LVL_W:0] act_lvl_o,
    input logic           stk_push,
    input logic           stk_pop,
    input logic           stk_full,
    input logic [LVL_W:0] stk_sp,
    input logic [LVL_W:0] stk_below
);

    localparam int CW = $clog2(ENTRY_LAT + 2);

    logic [CW-1:0] since_q;

    // Count cycles since the last preempt pulse, saturating past the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (preempt_o) begin
            since_q <= CW'(1);
        end else if ((since_q != '0) && (since_q <= CW'(ENTRY_LAT))) begin
            since_q <= since_q + CW'(1);
        end
    end

    // R4: a preempt starts a wait, so it never repeats next cycle.
    assert_preempt_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |=> !preempt_o);

    // R6: a non-tail entry comes exactly ENTRY_LAT cycles after its preempt.
    assert_entry_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_o && !tail_o) |-> (since_q == CW'(ENTRY_LAT)));

    // R5: a pushed level is strictly more urgent than the one it nests over.
    assert_nest_strict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> (act_lvl_o < $past(act_lvl_o)));

    // R8: a pop restores the level that sat beneath the top.
    assert_pop_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop |=> (act_lvl_o == $past(stk_below)));

    // R9: a tail-chain keeps the depth.
    assert_tail_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tail_o |=> (stk_sp == $past(stk_sp)));

    // R9: the chained level beats the level that would have been restored.
    assert_tail_beats_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tail_o |=> (act_lvl_o < $past(stk_below)));

    // R10: strict nesting never pushes into a full stack.
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_push && stk_full));

endmodule

bind irq_nest_arbiter irq_nest_arbiter_chk #(
    .LVL_W     (LVL_W),
    .ENTRY_LAT (ENTRY_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .preempt_o (preempt_o),
    .enter_o   (enter_o),
    .tail_o    (tail_o),
    .act_lvl_o (act_lvl_o),
    .stk_push  (stk_push),
    .stk_pop   (stk_pop),
    .stk_full  (stk_full),
    .stk_sp    (stk_sp),
    .stk_below (stk_below)
);

// File: tb/irq_nest_arbiter_tb_top.sv
// Bench for the resolver in a small build: 6 sources, 4 levels, wait of 3.
module irq_nest_arbiter_tb_top;

    localparam int NS   = 6;
    localparam int PW   = 8;
    localparam int LW   = 2;
    localparam int LAT  = 3;
    localparam int IDW  = 3;
    localparam int IDLE = 1 << LW;

    logic           clk;
    logic           rst_n;
    logic [NS-1:0]  pend;
    logic           we;
    logic [IDW-1:0] waddr;
    logic [PW-1:0]  wdata;
    logic [IDW-1:0] raddr;
    logic [PW-1:0]  rdata;
    logic           exc_ret;
    logic           sel_valid;
    logic [IDW-1:0] sel_id;
    logic           preempt;
    logic           enter;
    logic [IDW-1:0] enter_id;
    logic           tail;
    logic [LW:0]    act_lvl;

    int n_chk = 0;
    int n_err = 0;
    int lvl_tab [NS];

    irq_nest_arbiter #(
        .NUM_SRC   (NS),
        .PRIO_W    (PW),
        .LVL_W     (LW),
        .ENTRY_LAT (LAT),
        .ID_W      (IDW)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_i       (pend),
        .prio_we_i    (we),
        .prio_waddr_i (waddr),
        .prio_wdata_i (wdata),
        .prio_raddr_i (raddr),
        .prio_rdata_o (rdata),
        .exc_ret_i    (exc_ret),
        .sel_valid_o  (sel_valid),
        .sel_id_o     (sel_id),
        .preempt_o    (preempt),
        .enter_o      (enter),
        .enter_id_o   (enter_id),
        .tail_o       (tail),
        .act_lvl_o    (act_lvl)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance one clock and land on the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        pend    = '0;
        we      = 1'b0;
        exc_ret = 1'b0;
        waddr   = '0;
        wdata   = '0;
        raddr   = '0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr_prio(input int id, input int value);
        we    = 1'b1;
        waddr = IDW'(id);
        wdata = PW'(value);
        step();
        we = 1'b0;
    endtask

    // Store a level with junk in the dropped low bits and track it.
    task automatic set_lvl(input int id, input int lvl);
        wr_prio(id, (lvl << (PW - LW)) | ((id * 13 + 7) & 8'h3f));
        lvl_tab[id] = lvl;
    endtask

    // Raise one source over the current nest and see it through entry.
    task automatic enter_one(input int id, input int lvl);
        pend[id] = 1'b1;
        #1;
        chk("R4 preempt on more urgent pending", int'(preempt), 1);
        chk("R2 selected id at preempt", int'(sel_id), id);
        for (int k = 1; k <= LAT; k++) begin
            step();
            #1;
            if (k < LAT) begin
                chk("R6 no entry before wait ends", int'(enter), 0);
            end else begin
                chk("R6 entry after wait", int'(enter), 1);
                chk("R6 entry id", int'(enter_id), id);
                chk("R6 entry is not a tail-chain", int'(tail), 0);
            end
        end
        step();
        pend[id] = 1'b0;
        #1;
        chk("R6 active level after entry", int'(act_lvl), lvl);
    endtask

    // Return from the running handler with expected tail/level outcome.
    task automatic ret_chk(input int exp_tail, input int exp_id, input int exp_act);
        exc_ret = 1'b1;
        #1;
        chk("R9 tail flag at return", int'(tail), exp_tail);
        chk("R9 entry flag at return", int'(enter), exp_tail);
        if (exp_tail != 0) begin
            chk("R9 tail-chained id", int'(enter_id), exp_id);
        end
        step();
        exc_ret = 1'b0;
        if (exp_tail != 0) begin
            pend[exp_id] = 1'b0;
        end
        #1;
        chk("R8 active level after return", int'(act_lvl), exp_act);
    endtask

    // Sweep every pending pattern against the current level table.
    task automatic sweep(input string tag);
        for (int pat = 0; pat < (1 << NS); pat++) begin
            int best;
            int best_lvl;
            best     = -1;
            best_lvl = IDLE;
            for (int i = 0; i < NS; i++) begin
                if (((pat >> i) & 1) != 0 && lvl_tab[i] < best_lvl) begin
                    best     = i;
                    best_lvl = lvl_tab[i];
                end
            end
            pend = NS'(pat);
            #1;
            chk({tag, " R2 valid"}, int'(sel_valid), (pat != 0) ? 1 : 0);
            if (pat != 0) begin
                chk({tag, " R2/R3 winner"}, int'(sel_id), best);
            end
            step();
        end
        pend = '0;
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: actual run still busy, expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();

        // R11: reset state.
        #1;
        chk("R11 idle active level", int'(act_lvl), IDLE);
        chk("R11 no preempt", int'(preempt), 0);
        chk("R11 no entry", int'(enter), 0);
        chk("R11 no tail", int'(tail), 0);
        chk("R2 nothing selected", int'(sel_valid), 0);
        for (int i = 0; i < NS; i++) begin
            raddr = IDW'(i);
            #1;
            chk("R11 priority cleared", int'(rdata), 0);
        end
        step();

        // R1: readback keeps upper bits only; out-of-range writes ignored.
        for (int i = 0; i < NS; i++) begin
            wr_prio(i, (i * 37 + 91) & 8'hff);
        end
        wr_prio(6, 8'hff);
        wr_prio(7, 8'hff);
        for (int i = 0; i < NS; i++) begin
            raddr = IDW'(i);
            #1;
            chk("R1 readback upper bits", int'(rdata), ((i * 37 + 91) & 8'hff) & 8'hc0);
        end
        raddr = IDW'(6);
        #1;
        chk("R1 out-of-range read", int'(rdata), 0);
        raddr = IDW'(7);
        #1;
        chk("R1 out-of-range read", int'(rdata), 0);
        step();

        // R2/R3: exhaustive pending sweeps under three level maps.
        for (int i = 0; i < NS; i++) set_lvl(i, 1);
        sweep("equal levels");
        for (int i = 0; i < NS; i++) set_lvl(i, 3 - (i % 4));
        sweep("descending levels");
        for (int i = 0; i < NS; i++) set_lvl(i, (i * 3) % 4);
        sweep("mixed levels");

        // Nesting flow.
        do_reset();
        set_lvl(0, 3);
        set_lvl(1, 2);
        set_lvl(2, 1);
        set_lvl(3, 0);
        set_lvl(4, 2);
        set_lvl(5, 3);

        enter_one(0, 3);

        // R7: a return during the entry wait is ignored.
        pend[2] = 1'b1;
        #1;
        chk("R4 preempt over level 3", int'(preempt), 1);
        step();
        exc_ret = 1'b1;
        #1;
        chk("R7 return in wait gives no tail", int'(tail), 0);
        chk("R7 return in wait gives no entry", int'(enter), 0);
        step();
        exc_ret = 1'b0;
        #1;
        chk("R7 still waiting", int'(enter), 0);
        step();
        #1;
        chk("R7 entry on time despite return", int'(enter), 1);
        chk("R7 entry id", int'(enter_id), 2);
        step();
        pend[2] = 1'b0;
        #1;
        chk("R7 nested level", int'(act_lvl), 1);
        ret_chk(0, 0, 3);   // R7: proves the earlier return did not pop

        // R5: equal level waits.
        enter_one(1, 2);
        pend[4] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R5 equal level no preempt", int'(preempt), 0);
            chk("R5 level unchanged", int'(act_lvl), 2);
            step();
        end

        // R9: return chains into the waiting source, depth kept.
        ret_chk(1, 4, 2);
        ret_chk(0, 0, 3);   // R9: one entry remained below

        // R10: full nest over all four levels, then unwind.
        enter_one(1, 2);
        enter_one(2, 1);
        enter_one(3, 0);
        ret_chk(0, 0, 1);
        ret_chk(0, 0, 2);
        ret_chk(0, 0, 3);
        ret_chk(0, 0, IDLE); // R10 fully unwound

        // R7: return with an empty stack.
        ret_chk(0, 0, IDLE);

        // R8: pending equal to the restored level does not chain.
        enter_one(0, 3);
        enter_one(2, 1);
        pend[5] = 1'b1;
        #1;
        chk("R5 level 3 under level 1", int'(preempt), 0);
        ret_chk(0, 0, 3);
        #1;
        chk("R8 equal pending stays waiting", int'(preempt), 0);
        ret_chk(1, 5, 3);   // R9: chains over idle
        ret_chk(0, 0, IDLE);

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule